// File: doc/BRIEF.md
# Sample-and-Tune Throughput Regulator

This block keeps a time-critical hardware thread running at a chosen fraction of its own standalone speed. It shares a core with a second thread that has no time limit. The block never receives the standalone speed from outside. It finds that speed itself in a sample phase. During that phase the other thread is halted and the critical thread gets every resource. The phase opens with a warm-up stretch that is not measured, followed by a window in which the critical thread's commits are counted.

A tune phase follows, in which both threads run. The tune phase is cut into equal sub-periods. At the end of each sub-period the critical thread's commits are compared with a target. The target is the measured window count, scaled by the ratio of sub-period length to window length (1.5) and by a software-written fraction (the inverse slowdown). The critical thread's resource limit then moves one step up or down, and the other thread receives whatever the critical thread does not hold. The two phases alternate with no end.

The block only produces the limit values and the halt request. Enforcing the limits is left to the pipeline.

Top module: `ipc_share_regulator`

## Requirements
- R1: While reset is held, and in the first cycle after it, the block is in warm-up: `nctHalt` is 1, `ctLimit` equals CAP and `nctLimit` is 0.
- R2: For the whole sample phase (WARM_CYC warm-up cycles followed by MEAS_CYC measurement cycles), `nctHalt` is 1, `ctLimit` is CAP and `nctLimit` is 0.
- R3: Commits during warm-up and during the tune phase do not affect the measured count. Only the MEAS_CYC measurement cycles add to it.
- R4: The tune phase lasts NUM_SUB*SUB_CYC cycles. The sample phase then starts again.
- R5: In the first tune cycle `nctHalt` is 0 and `ctLimit` is CAP/2.
- R6: The target is floor(3*M*F/2^(FRAC_W+1)), where M is the measured count and F is `invSlow` read as an unsigned fraction F/2^FRAC_W. A sub-period's commit total includes its last cycle. If that total is below the target, `ctLimit` rises by STEP = CAP/16 from the next cycle on.
- R7: If the sub-period total is above the target, `ctLimit` falls by STEP from the next cycle on.
- R8: If the sub-period total equals the target, `ctLimit` is unchanged.
- R9: During tuning, `ctLimit` never goes above CAP or below STEP. A step that would cross a bound stops at that bound.
- R10: During tuning, `ctLimit` changes only in the cycle after a sub-period ends. The share carries over from one sub-period to the next.
- R11: `ctLimit + nctLimit` always equals CAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| commitCnt | input | COMMIT_W | Critical-thread instructions committed this cycle |
| invSlow | input | FRAC_W | Inverse slowdown as an unsigned fraction, written by software |
| ctLimit | output | LIM_W | Resource limit for the critical thread |
| nctLimit | output | LIM_W | Resource limit for the non-critical thread |
| nctHalt | output | 1 | Halt request for the non-critical thread |

## Verification
The bench builds the block with a 20-cycle warm-up, an 8-cycle window, 12-cycle sub-periods, 10 sub-periods and a capacity of 32. These values keep the 1.5 ratio between sub-period and window, so that a round takes 148 cycles. Ten steps of 2 from a start of 16 are enough to reach both clamps. A window rate of 4 against a tune rate of 2 at F = 128 lands exactly on the target, which exercises the hold case. Every cycle of 25 rounds, covering five fractions and five commit patterns, is compared against an arithmetic model of the schedule.

// File: rtl/ipc_reg_pkg.sv
package ipc_reg_pkg;

  typedef enum logic [1:0] {
    PH_WARM = 2'd0,
    PH_MEAS = 2'd1,
    PH_TUNE = 2'd2
  } phase_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic measClr;    // last warm-up cycle: clear window count
    logic measAcc;    // window cycle: accumulate commits
    logic tuneStart;  // last window cycle: load mid share
    logic perAcc;     // tune cycle: accumulate sub-period commits
    logic subEnd;     // last cycle of a sub-period: decide step
    logic sampleMode; // whole sample phase
  } strobe_t;

endpackage

// File: rtl/ipc_reg_ctrl.sv
module ipc_reg_ctrl
  import ipc_reg_pkg::*;
#(
  parameter int WARM_CYC = 50000,
  parameter int MEAS_CYC = 10000,
  parameter int SUB_CYC  = 15000,
  parameter int NUM_SUB  = 20
) (
  input  logic    clk,
  input  logic    rstN,
  output strobe_t stb
);

  localparam int TUNE_CYC = SUB_CYC * NUM_SUB;
  localparam int PH_MAX   = (TUNE_CYC > WARM_CYC) ?
                            ((TUNE_CYC > MEAS_CYC) ? TUNE_CYC : MEAS_CYC) :
                            ((WARM_CYC > MEAS_CYC) ? WARM_CYC : MEAS_CYC);
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int SUB_W    = $clog2(SUB_CYC + 1);

  phase_e           phase;
  logic [PH_W-1:0]  phaseCnt;
  logic [SUB_W-1:0] subCnt;

  logic warmLast, measLast, tuneLast, subLast;

  always_comb begin
    warmLast = (phase == PH_WARM) && (phaseCnt == PH_W'(WARM_CYC - 1));
    measLast = (phase == PH_MEAS) && (phaseCnt == PH_W'(MEAS_CYC - 1));
    tuneLast = (phase == PH_TUNE) && (phaseCnt == PH_W'(TUNE_CYC - 1));
    subLast  = (phase == PH_TUNE) && (subCnt == SUB_W'(SUB_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_WARM;
      phaseCnt <= '0;
      subCnt   <= '0;
    end else begin
      unique case (phase)
        PH_WARM: begin
          if (warmLast) begin
            phase    <= PH_MEAS;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_MEAS: begin
          if (measLast) begin
            phase    <= PH_TUNE;
            phaseCnt <= '0;
            subCnt   <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_TUNE: begin
          subCnt <= subLast ? '0 : subCnt + 1'b1;
          if (tuneLast) begin
            phase    <= PH_WARM;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          phase    <= PH_WARM;
          phaseCnt <= '0;
          subCnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    stb.measClr    = warmLast;
    stb.measAcc    = (phase == PH_MEAS);
    stb.tuneStart  = measLast;
    stb.perAcc     = (phase == PH_TUNE);
    stb.subEnd     = subLast;
    stb.sampleMode = (phase != PH_TUNE);
  end

endmodule

// File: rtl/ipc_reg_datapath.sv
module ipc_reg_datapath
  import ipc_reg_pkg::*;
#(
  parameter int COMMIT_W = 4,
  parameter int FRAC_W   = 8,
  parameter int MEAS_CYC = 10000,
  parameter int SUB_CYC  = 15000,
  parameter int CAP      = 64,
  localparam int LIM_W   = $clog2(CAP + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [COMMIT_W-1:0] commitCnt,
  input  logic [FRAC_W-1:0]   invSlow,
  output logic [LIM_W-1:0]    ctLimit,
  output logic [LIM_W-1:0]    nctLimit,
  output logic                nctHalt
);

  localparam int MAX_C  = (1 << COMMIT_W) - 1;
  localparam int SAMP_W = $clog2(MEAS_CYC * MAX_C + 1);
  localparam int PER_W  = $clog2(SUB_CYC * MAX_C + 1);
  localparam int M3_W   = SAMP_W + 2;
  localparam int PROD_W = M3_W + FRAC_W;
  localparam int TGT_W  = PROD_W - (FRAC_W + 1);
  localparam int CMP_W  = (TGT_W > PER_W) ? TGT_W : PER_W;
  localparam int STEP   = CAP / 16;
  localparam int HALF   = CAP / 2;

  logic [SAMP_W-1:0] measCnt;
  logic [PER_W-1:0]  perCnt;
  logic [LIM_W-1:0]  share;

  logic [M3_W-1:0]   meas3;
  logic [PROD_W-1:0] prod;
  logic [CMP_W-1:0]  target, perTotal;
  logic [LIM_W:0]    upVal;
  logic [LIM_W-1:0]  nextShare;

  // target = 3*M*F >> (FRAC_W+1), built with shifts and adds
  always_comb begin
    meas3 = (M3_W'(measCnt) << 1) + M3_W'(measCnt);
    prod  = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (invSlow[i]) prod = prod + (PROD_W'(meas3) << i);
    end
    target   = CMP_W'(prod >> (FRAC_W + 1));
    perTotal = CMP_W'(perCnt) + CMP_W'(commitCnt);
  end

  always_comb begin
    upVal     = (LIM_W + 1)'(share) + (LIM_W + 1)'(STEP);
    nextShare = share;
    if (perTotal < target) begin
      nextShare = (upVal > (LIM_W + 1)'(CAP)) ? LIM_W'(CAP) : upVal[LIM_W-1:0];
    end else if (perTotal > target) begin
      nextShare = (share > LIM_W'(STEP)) ? share - LIM_W'(STEP) : LIM_W'(STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      measCnt <= '0;
      perCnt  <= '0;
      share   <= LIM_W'(HALF);
    end else begin
      if (stb.measClr)      measCnt <= '0;
      else if (stb.measAcc) measCnt <= measCnt + SAMP_W'(commitCnt);

      if (stb.tuneStart || stb.subEnd) perCnt <= '0;
      else if (stb.perAcc)             perCnt <= perCnt + PER_W'(commitCnt);

      if (stb.tuneStart)   share <= LIM_W'(HALF);
      else if (stb.subEnd) share <= nextShare;
    end
  end

  always_comb begin
    nctHalt  = stb.sampleMode;
    ctLimit  = stb.sampleMode ? LIM_W'(CAP) : share;
    nctLimit = LIM_W'(CAP) - ctLimit;
  end

endmodule

// File: rtl/ipc_share_regulator.sv
module ipc_share_regulator
  import ipc_reg_pkg::*;
#(
  parameter int WARM_CYC = 50000,
  parameter int MEAS_CYC = 10000,
  parameter int SUB_CYC  = 15000,
  parameter int NUM_SUB  = 20,
  parameter int CAP      = 64,
  parameter int COMMIT_W = 4,
  parameter int FRAC_W   = 8,
  localparam int LIM_W   = $clog2(CAP + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [COMMIT_W-1:0] commitCnt,
  input  logic [FRAC_W-1:0]   invSlow,
  output logic [LIM_W-1:0]    ctLimit,
  output logic [LIM_W-1:0]    nctLimit,
  output logic                nctHalt
);

  strobe_t stb;

  ipc_reg_ctrl #(
    .WARM_CYC(WARM_CYC), .MEAS_CYC(MEAS_CYC),
    .SUB_CYC(SUB_CYC),   .NUM_SUB(NUM_SUB)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .stb(stb)
  );

  ipc_reg_datapath #(
    .COMMIT_W(COMMIT_W), .FRAC_W(FRAC_W), .MEAS_CYC(MEAS_CYC),
    .SUB_CYC(SUB_CYC),   .CAP(CAP)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .commitCnt(commitCnt), .invSlow(invSlow),
    .ctLimit(ctLimit), .nctLimit(nctLimit), .nctHalt(nctHalt)
  );

endmodule

// File: rtl/ipc_share_regulator_chk.sv
module ipc_share_regulator_chk #(
  parameter int CAP = 64,
  localparam int LIM_W = $clog2(CAP + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [LIM_W-1:0] ctLimit,
  input logic [LIM_W-1:0] nctLimit,
  input logic             nctHalt
);

  localparam int STEP = CAP / 16;

  // R2
  sample_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    nctHalt |-> (ctLimit == LIM_W'(CAP) && nctLimit == '0));

  // R11
  sum_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(ctLimit) + 32'(nctLimit)) == CAP);

  // R9
  clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nctHalt |-> (ctLimit >= LIM_W'(STEP) && ctLimit <= LIM_W'(CAP)));

  // R5
  tune_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nctHalt) |-> ctLimit == LIM_W'(CAP / 2));

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nctHalt && !$past(nctHalt) && !$stable(ctLimit)) |->
      (32'(ctLimit) == 32'($past(ctLimit)) + STEP ||
       32'(ctLimit) + STEP == 32'($past(ctLimit)) ||
       32'(ctLimit) == CAP || 32'(ctLimit) == STEP));

endmodule

bind ipc_share_regulator ipc_share_regulator_chk #(.CAP(CAP)) uChk (
  .clk(clk), .rstN(rstN), .ctLimit(ctLimit),
  .nctLimit(nctLimit), .nctHalt(nctHalt)
);

// File: tb/tb_ipc_share_regulator.sv
module tb_ipc_share_regulator;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 20;
  localparam int M    = 8;
  localparam int S    = 12;
  localparam int N    = 10;
  localparam int CAP  = 32;
  localparam int STEP = CAP / 16;
  localparam int LW   = $clog2(CAP + 1);
  localparam int ROUND = W + M + S * N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    commitCnt = '0;
  logic [7:0]    invSlow = '0;
  logic [LW-1:0] ctLimit, nctLimit;
  logic          nctHalt;

  ipc_share_regulator #(
    .WARM_CYC(W), .MEAS_CYC(M), .SUB_CYC(S), .NUM_SUB(N),
    .CAP(CAP), .COMMIT_W(4), .FRAC_W(8)
  ) dut (
    .clk(clk), .rstN(rstN), .commitCnt(commitCnt), .invSlow(invSlow),
    .ctLimit(ctLimit), .nctLimit(nctLimit), .nctHalt(nctHalt)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference schedule: 0 warm-up, 1 window, 2 tune
  int mPh = 0, mCnt = 0, mSub = 0, mMeas = 0, mPer = 0, mShare = CAP / 2;
  int curPat = 0;
  string mTag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkOutputs();
    int expCt, expN, expH;
    expCt = (mPh == 2) ? mShare : CAP;
    expN  = CAP - expCt;
    expH  = (mPh == 2) ? 0 : 1;
    chk(int'(ctLimit) == expCt, {mTag, " ctLimit"}, int'(ctLimit), expCt);
    chk(int'(nctLimit) == expN, {mTag, " nctLimit"}, int'(nctLimit), expN);
    chk(int'(nctHalt) == expH, {mTag, " nctHalt"}, int'(nctHalt), expH);
    chk(int'(ctLimit) + int'(nctLimit) == CAP, "R11 sum", int'(ctLimit) + int'(nctLimit), CAP);
  endtask

  function automatic int pick(input int pat, input int ph, input int cyc);
    case (pat)
      0: return 3;
      1: return (ph == 0) ? 15 : (ph == 1) ? 4 : 0;
      2: return (ph == 0) ? 9 : (ph == 1) ? 1 : 7;
      3: return (ph == 1) ? 4 : (ph == 2) ? 2 : 11;
      default: return (ph == 0) ? 0 : (cyc * 5) % 16;
    endcase
  endfunction

  task automatic stepCycle(input int c);
    int tot, tgt, ns;
    string pre;
    commitCnt = 4'(c);
    pre = (curPat == 1) ? "R3 " : "";
    case (mPh)
      0: begin
        mTag = "R2";
        if (mCnt == W - 1) begin mPh = 1; mCnt = 0; mMeas = 0; end
        else mCnt++;
      end
      1: begin
        mMeas += c;
        if (mCnt == M - 1) begin
          mPh = 2; mCnt = 0; mSub = 0; mPer = 0; mShare = CAP / 2; mTag = "R5";
        end else begin
          mCnt++; mTag = "R2";
        end
      end
      default: begin
        tot = mPer + c;
        tgt = (3 * mMeas * int'(invSlow)) >> 9;
        if (mSub == S - 1) begin
          if (tot < tgt) begin
            ns = mShare + STEP;
            mTag = {pre, (ns > CAP) ? "R9 up" : "R6"};
            if (ns > CAP) ns = CAP;
          end else if (tot > tgt) begin
            ns = mShare - STEP;
            mTag = {pre, (ns < STEP) ? "R9 down" : "R7"};
            if (ns < STEP) ns = STEP;
          end else begin
            ns = mShare; mTag = {pre, "R8"};
          end
          mShare = ns; mPer = 0; mSub = 0;
        end else begin
          mPer = tot; mSub++; mTag = "R10";
        end
        if (mCnt == S * N - 1) begin mPh = 0; mCnt = 0; mTag = "R4"; end
        else mCnt++;
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    checkOutputs();
  endtask

  initial begin
    int invs[5] = '{0, 64, 128, 200, 255};
    int cyc;
    repeat (3) begin
      @(negedge clk);
      checkOutputs(); // R1 under reset (checked after first edge)
    end
    rstN = 1'b1;
    mTag = "R1";
    cyc = 0;
    for (int i = 0; i < 5; i++) begin
      for (int p = 0; p < 5; p++) begin
        invSlow = 8'(invs[i]);
        curPat = p;
        for (int k = 0; k < ROUND; k++) begin
          stepCycle(pick(p, mPh, cyc));
          cyc++;
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule